// File: doc/BRIEF.md
# Signed-Count Logical Shifter with Carry

This unit is the shift stage of a DSP-style datapath. Each cycle it may accept a 32-bit source word and a count word. Only a small signed field at the bottom of the count matters. Its sign selects the direction of a logical shift, and its magnitude sets the distance. The shifted word goes to a destination register, and a carry flag records the last bit that left the word. The source itself is never altered; the unit only produces a new value.

A positive count moves bits toward the most-significant end and a negative count moves them toward the least-significant end. Vacated positions always fill with zeros, because no shift ever extends the sign. Counts of 32 or more in either direction clear the result. A zero count passes the source through and leaves the carry untouched. Results appear one clock after the input strobe, together with a one-cycle valid pulse. The result and carry hold their values between strobes.

Top module: `lshift_carry_unit`

## Requirements
- R1: Only count_word[6:0] affects the outcome; bits 31 down to 7 of count_word are ignored.
- R2: count_word[6:0] is a two's-complement value in -64..+63; bit 6 set means a right shift by the negated value, bit 6 clear with a nonzero value means a left shift.
- R3: A left shift by n (1..31) gives src_word << n with zeros in the low n bits, and carry_flag becomes source bit 32-n (the last bit pushed out past bit 31).
- R4: A right shift by n (1..31) gives src_word >> n with zeros in the high n bits, and carry_flag becomes source bit n-1 (the last bit pushed out past bit 0).
- R5: A count field of zero gives res_word equal to src_word and leaves carry_flag at its previous value.
- R6: A shift magnitude of exactly 32 gives an all-zero result with carry equal to source bit 0 (left) or source bit 31 (right); a magnitude above 32 gives a zero result and a zero carry.
- R7: When in_valid is high at a rising edge, res_word and carry_flag update at that edge and res_valid is high for the following cycle only; when in_valid is low, res_valid is low and res_word and carry_flag keep their values.
- R8: rst_n low clears res_word, carry_flag and res_valid at once, without waiting for a clock; its release takes effect through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source and count are presented this cycle |
| src_word | input | 32 | Word to be shifted |
| count_word | input | 32 | Shift count; low seven bits used as a signed amount |
| res_word | output | 32 | Registered shifted result |
| carry_flag | output | 1 | Last bit shifted out |
| res_valid | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The embedded properties assume that src_word and count_word carry known values whenever in_valid is high, and that rst_n is not released in the middle of a strobe. The stimulus sets every input to a defined value before the first edge. It changes inputs only on falling edges, asserts reset only while the input is idle, and holds back new strobes until the synchronized release has passed. The count patterns cover both signs, zero, the limits of ±32 and ±33, the extremes -64 and +63, and counts whose upper bits are filled with ones.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/lsc_reset_sync.sv
module lsc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/lsc_count_decode.sv
module lsc_count_decode
  import lsc_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [CNT_W-1:0] cnt_field,
  output shift_dir_e       dir,
  output logic [CNT_W-1:0] mag,
  output logic             is_zero
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic neg;

  always_comb begin
    neg     = cnt_field[CNT_W-1];
    dir     = neg ? DIR_RIGHT : DIR_LEFT;
    // The most negative value negates onto itself, which read unsigned is its magnitude.
    mag     = neg ? ((~cnt_field) + ONE) : cnt_field;
    is_zero = (cnt_field == '0);
  end

  always_comb begin
    if (!$isunknown(cnt_field)) begin
      a_r2_dir_sign : assert ((dir == DIR_RIGHT) == cnt_field[CNT_W-1])
        else $error("a_r2_dir_sign");
      a_r2_mag_nonzero : assert (is_zero == (mag == '0))
        else $error("a_r2_mag_nonzero");
    end
  end
endmodule

// File: rtl/lsc_shift_core.sv
module lsc_shift_core
  import lsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 7
) (
  input  logic [DATA_W-1:0] src,
  input  shift_dir_e        dir,
  input  logic [CNT_W-1:0]  mag,
  output logic [DATA_W-1:0] res,
  output logic              carry
);
  localparam int            EXT_W = DATA_W + 1;
  localparam logic [CNT_W:0] W_LIM = (CNT_W + 1)'(DATA_W);

  logic [EXT_W-1:0] left_ext;
  logic [EXT_W-1:0] right_ext;

  // One guard bit on the exit side of each path catches the last bit shifted out.
  always_comb begin
    left_ext  = {1'b0, src} << mag;
    right_ext = {src, 1'b0} >> mag;
    if (dir == DIR_LEFT) begin
      res   = left_ext[DATA_W-1:0];
      carry = left_ext[DATA_W];
    end else begin
      res   = right_ext[DATA_W:1];
      carry = right_ext[0];
    end
  end

  always_comb begin
    if (!$isunknown({src, dir, mag})) begin
      if ({1'b0, mag} > W_LIM) begin
        a_r6_over_range : assert (res == '0 && carry == 1'b0)
          else $error("a_r6_over_range");
      end
      if (dir == DIR_LEFT && mag != '0 && {1'b0, mag} <= W_LIM) begin
        a_r3_low_fill : assert (res[0] == 1'b0)
          else $error("a_r3_low_fill");
      end
      if (dir == DIR_RIGHT && mag != '0 && {1'b0, mag} <= W_LIM) begin
        a_r4_high_fill : assert (res[DATA_W-1] == 1'b0)
          else $error("a_r4_high_fill");
      end
      if (mag == '0) begin
        a_r5_pass : assert (res == src)
          else $error("a_r5_pass");
      end
    end
  end
endmodule

// File: rtl/lsc_out_reg.sv
module lsc_out_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              keep_carry,
  input  logic [DATA_W-1:0] res_in,
  input  logic              carry_in,
  output logic [DATA_W-1:0] res_q,
  output logic              carry_q,
  output logic              vld_q
);
  logic [DATA_W-1:0] res_d;
  logic              carry_d;
  logic              vld_d;
  logic              res_en;
  logic              carry_en;

  always_comb begin
    res_en   = load;
    carry_en = load && !keep_carry;
    res_d    = res_en   ? res_in   : res_q;
    carry_d  = carry_en ? carry_in : carry_q;
    vld_d    = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      carry_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      res_q   <= res_d;
      carry_q <= carry_d;
      vld_q   <= vld_d;
    end
  end

  a_r7_pulse : assert property (@(posedge clk) disable iff (!rst_n)
    load |=> vld_q) else $error("a_r7_pulse");
  a_r7_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !vld_q) else $error("a_r7_quiet");
  a_r7_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(res_q) && $stable(carry_q))) else $error("a_r7_hold");
  a_r5_carry_keep : assert property (@(posedge clk) disable iff (!rst_n)
    (load && keep_carry) |=> $stable(carry_q)) else $error("a_r5_carry_keep");
endmodule

// File: rtl/lshift_carry_unit.sv
module lshift_carry_unit
  import lsc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src_word,
  input  logic [DATA_W-1:0] count_word,
  output logic [DATA_W-1:0] res_word,
  output logic              carry_flag,
  output logic              res_valid
);
  logic             rst_n_int;
  shift_dir_e       dir;
  logic [CNT_W-1:0] mag;
  logic             cnt_zero;
  logic [DATA_W-1:0] shifted;
  logic             shift_carry;
  logic             unused_cnt_hi;

  // The bits above the count field take no part in the shift.
  assign unused_cnt_hi = ^count_word[DATA_W-1:CNT_W];

  lsc_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  lsc_count_decode #(.CNT_W(CNT_W)) u_dec (
    .cnt_field (count_word[CNT_W-1:0]),
    .dir       (dir),
    .mag       (mag),
    .is_zero   (cnt_zero)
  );

  lsc_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .src   (src_word),
    .dir   (dir),
    .mag   (mag),
    .res   (shifted),
    .carry (shift_carry)
  );

  lsc_out_reg #(.DATA_W(DATA_W)) u_oreg (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .load       (in_valid),
    .keep_carry (cnt_zero),
    .res_in     (shifted),
    .carry_in   (shift_carry),
    .res_q      (res_word),
    .carry_q    (carry_flag),
    .vld_q      (res_valid)
  );

  a_r8_reset_clear : assert property (@(posedge clk)
    !rst_n |-> (res_word == '0 && !carry_flag && !res_valid))
    else $error("a_r8_reset_clear");
endmodule

// File: tb/lshift_carry_unit_bench.sv
module lshift_carry_unit_bench;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         carry;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] src_word = '0;
  logic [W-1:0] count_word = '0;
  logic [W-1:0] res_word;
  logic         carry_flag;
  logic         res_valid;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  exp_t  q[$];
  logic  model_carry = 1'b0;
  logic [W-1:0] last_res = '0;
  logic  last_carry = 1'b0;

  always #10 clk = ~clk;

  lshift_carry_unit u_lshift_carry_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .src_word   (src_word),
    .count_word (count_word),
    .res_word   (res_word),
    .carry_flag (carry_flag),
    .res_valid  (res_valid)
  );

  task automatic check(input bit ok, input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bit-at-a-time reference: the last bit that leaves the word is the carry.
  task automatic push(input logic [W-1:0] s, input logic [W-1:0] c, input string tag);
    exep_t_dummy();
    begin
      exp_t e;
      int amt;
      logic [W-1:0] v;
      logic cy;
      amt = $signed(c[6:0]);
      v = s;
      cy = model_carry;
      if (amt > 0) begin
        for (int i = 0; i < amt; i++) begin cy = v[W-1]; v = v << 1; end
      end else if (amt < 0) begin
        for (int i = 0; i < -amt; i++) begin cy = v[0]; v = v >> 1; end
      end
      model_carry = cy;
      e.res = v; e.carry = cy; e.tag = tag;
      @(negedge clk);
      q.push_back(e);
      in_valid = 1'b1; src_word = s; count_word = c;
    end
  endtask

  task automatic exep_t_dummy();
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; src_word = 32'hDEAD_BEEF; count_word = 32'h0000_0005;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  // Monitor: compare each fresh result against the queue; otherwise outputs must hold.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (res_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R7 unexpected res_valid", {carry_flag, res_word}, '0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({carry_flag, res_word} === {e.carry, e.res}, e.tag,
                {carry_flag, res_word}, {e.carry, e.res});
          last_res = e.res; last_carry = e.carry;
        end
      end else begin
        check({carry_flag, res_word} === {last_carry, last_res}, "R7 hold while idle",
              {carry_flag, res_word}, {last_carry, last_res});
      end
    end
  end

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    #5;
    check({carry_flag, res_word, res_valid} === '0, "R8 reset state",
          {carry_flag, res_word}, '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    push(32'h8000_0001, 32'h0000_0001, "R3 left 1");
    push(32'hF000_000F, 32'h0000_0004, "R3 left 4");
    push(32'h0000_0001, 32'h0000_001F, "R3 left 31");
    push(32'h8000_0001, 32'h0000_007F, "R4 right 1");
    push(32'h1234_5680, 32'h0000_0078, "R4 right 8");
    push(32'h8000_0000, 32'h0000_0061, "R4 right 31");
    idle(3);
    push(32'hFFFF_FFFF, 32'h0000_0001, "R5 setup carry one");
    push(32'hA5A5_A5A5, 32'h0000_0000, "R5 zero keeps carry one");
    push(32'h0000_0001, 32'h0000_0001, "R5 setup carry zero");
    push(32'h5A5A_5A5A, 32'hFFFF_FF80, "R1 R5 zero field with upper bits set");
    push(32'h8000_0001, 32'hFFFF_FF01, "R1 upper bits set left 1");
    push(32'h8000_0001, 32'h1234_567F, "R1 R2 upper bits set right 1");
    idle(2);
    push(32'h0000_0001, 32'h0000_0020, "R6 left 32 carry bit0");
    push(32'h8000_0000, 32'h0000_0060, "R6 right 32 carry bit31");
    push(32'hFFFF_FFFF, 32'h0000_0021, "R6 left 33");
    push(32'hFFFF_FFFF, 32'h0000_005F, "R6 right 33");
    push(32'hFFFF_FFFF, 32'h0000_003F, "R6 R2 left 63");
    push(32'hFFFF_FFFF, 32'h0000_0040, "R6 R2 right 64");
    push(32'hFFFF_FFFE, 32'h0000_0020, "R6 left 32 carry zero");
    idle(3);

    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] s;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      s = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      push(s, {lfsr[31:7], lfsr[6:0]}, "R2 mixed stream");
      if (lfsr[3]) idle(1 + int'(lfsr[5:4]));
    end
    idle(4);

    // Reset while idle clears everything without a clock edge.
    #3;
    rst_n = 1'b0;
    #1;
    check({carry_flag, res_word, res_valid} === '0, "R8 async clear",
          {carry_flag, res_word}, '0);
    last_res = '0; last_carry = 1'b0; model_carry = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    push(32'h0000_00F0, 32'h0000_0000, "R8 R5 carry zero after reset");
    push(32'h0000_00F0, 32'h0000_007C, "R4 right 4 after reset");
    idle(3);

    done = 1'b1;
    check(q.size() == 0, "R7 all results delivered", q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule